// File: doc/BRIEF.md
# Card Command Framer for SPI Mode

This block sends a single memory-card command over a byte-wide SPI master and returns the card's one-byte status reply. A start strobe latches a 6-bit command index and a 32-bit argument. The block then drives a request/done byte handshake toward an SPI master that serializes each byte. It emits one filler byte, then the six-byte command packet, and then polls for the reply.

The packet holds a header byte (start bit 0, transmit bit 1, command index), the argument with its most significant byte first, and a trailer. The trailer carries a CRC7 that is built one byte at a time as the packet bytes go out. Polling reads at most a fixed number of bytes. A byte with bit 7 clear ends the poll early, unless it arrived in the first poll slot. If no such byte arrives, the last byte read is reported. A reported 0xFF means no card answered.

The state machine has five states: IDLE, FILL (filler byte), FRAME (six packet bytes), POLL (reply slots) and FIN (one-cycle completion).

Transitions:
- IDLE→FILL on start.
- FILL→FRAME when the filler transfer completes.
- FRAME→POLL when the sixth packet byte completes.
- POLL→FIN when an acceptable reply arrives, or when the last slot completes.
- FIN→IDLE unconditionally.

Reply bits, least significant first, mean:
- bit 0: idle
- bit 1: erase reset
- bit 2: illegal command
- bit 3: CRC error
- bit 4: erase sequence error
- bit 5: address error
- bit 6: parameter error

Top module: `sd_cmd_framer`

## Requirements
- R1: The first byte transferred after start is the filler value 0xFF.
- R2: The second byte is 0x40 OR'ed with the 6-bit command index (bits 7:6 = 01).
- R3: Bytes three to six are the 32-bit argument, bits 31:24 first and bits 7:0 last.
- R4: The seventh byte is {crc7, 1'b1}. The CRC7 uses polynomial x^7+x^3+1, starts from zero and takes the five preceding packet bytes MSB first. Command 0 with argument 0 gives 0x95.
- R5: The byte read in the first poll slot is never taken as the reply, even when its bit 7 is clear.
- R6: In poll slot 2 or later, a byte with bit 7 clear becomes the reply, and no further transfer is requested.
- R7: When all POLL_SLOTS (default 8) poll bytes have bit 7 set, the reply is the last byte read, and exactly 7+POLL_SLOTS transfers occur.
- R8: `no_resp` is high exactly when the reported reply equals 0xFF.
- R9: `finish` pulses high for exactly one cycle per command, and `resp` is valid during that cycle.
- R10: A start strobe that arrives while a command is in progress is ignored. The frame that goes out is unchanged, and only one `finish` occurs.
- R11: `resp` and `no_resp` change only in the cycle in which `finish` is high, and they hold their values between commands.
- R12: After reset, `spi_req` and `finish` are low, `resp` is 0x00 and `no_resp` is low.
- R13: While `spi_req` is high and `spi_done` is low, `spi_req` stays high and `spi_tx` is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (honoured only while idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| spi_req | output | 1 | Byte transfer request, held until done |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | One-cycle transfer completion |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| resp | output | 8 | Reported status byte |
| no_resp | output | 1 | Reported byte was 0xFF |
| finish | output | 1 | One-cycle completion pulse |

## Verification
The bench puts a bit-7-clear byte in the first poll slot. A design that accepts it ends the poll one slot early and reports a stale value. It feeds all eight slots with bit 7 set, both 0xFF and other values. A design with an off-by-one slot limit issues a wrong number of transfers or reports the wrong last byte. Known trailers for command 0 and command 8 expose a CRC with the wrong polynomial, a wrong bit order or a wrong seed. A second start issued in the middle of a command catches a design that restarts or relatches its operands.

// File: rtl/sd_cmd_framer_pkg.sv
package sd_cmd_framer_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_FRAME,
        S_POLL,
        S_FIN
    } fr_state_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [6:0] CRC7_POLY   = 7'h09;
    localparam int         FRAME_BYTES = 6;
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] din,
    output logic [6:0] crc
);
    import sd_cmd_framer_pkg::*;

    logic [6:0] crc_q;

    function automatic logic [6:0] crc7_byte(input logic [6:0] c, input logic [7:0] b);
        logic [6:0] r;
        logic       fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[6] ^ b[i];
            r  = {r[5:0], 1'b0};
            if (fb) r = r ^ CRC7_POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= '0;
        else if (clr)    crc_q <= '0;
        else if (step)   crc_q <= crc7_byte(crc_q, din);
    end

    assign crc = crc_q;

    // R4: a cleared register starts every packet at zero
    a_r4_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == 7'd0));
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq #(
    parameter int POLL_SLOTS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [6:0]  crc_val,
    output logic        crc_clr,
    output logic        crc_step,
    output logic [7:0]  crc_byte,
    output logic        spi_req,
    output logic [7:0]  spi_tx,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx,
    output logic [7:0]  resp,
    output logic        no_resp,
    output logic        finish
);
    import sd_cmd_framer_pkg::*;

    localparam int MAXCNT = (POLL_SLOTS > FRAME_BYTES) ? POLL_SLOTS : FRAME_BYTES;
    localparam int PW     = $clog2(MAXCNT);
    localparam logic [PW-1:0] LAST_FRAME = PW'(FRAME_BYTES - 1);
    localparam logic [PW-1:0] LAST_SLOT  = PW'(POLL_SLOTS - 1);

    fr_state_t     state, state_nx;
    logic [PW-1:0] pos;
    logic [5:0]    idx_q;
    logic [31:0]   arg_q;
    logic [7:0]    resp_q;
    logic          nores_q;
    logic [7:0]    frame_byte;
    logic          poll_end;

    // packet byte selected by position
    always_comb begin
        unique case (pos)
            PW'(0):  frame_byte = {2'b01, idx_q};
            PW'(1):  frame_byte = arg_q[31:24];
            PW'(2):  frame_byte = arg_q[23:16];
            PW'(3):  frame_byte = arg_q[15:8];
            PW'(4):  frame_byte = arg_q[7:0];
            default: frame_byte = {crc_val, 1'b1};
        endcase
    end

    assign poll_end = spi_done && (((pos != '0) && !spi_rx[7]) || (pos == LAST_SLOT));

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_FILL;
            S_FILL:  if (spi_done) state_nx = S_FRAME;
            S_FRAME: if (spi_done && pos == LAST_FRAME) state_nx = S_POLL;
            S_POLL:  if (poll_end) state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pos     <= '0;
            idx_q   <= '0;
            arg_q   <= '0;
            resp_q  <= 8'h00;
            nores_q <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                S_IDLE: if (start) begin
                    idx_q <= cmd_index;
                    arg_q <= cmd_arg;
                    pos   <= '0;
                end
                S_FILL:  if (spi_done) pos <= '0;
                S_FRAME: if (spi_done) pos <= (pos == LAST_FRAME) ? '0 : pos + 1'b1;
                S_POLL: if (spi_done) begin
                    pos <= pos + 1'b1;
                    if (poll_end) begin
                        resp_q  <= spi_rx;
                        nores_q <= (spi_rx == 8'hFF);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_req  = 1'b0;
        spi_tx   = FILL_BYTE;
        finish   = 1'b0;
        crc_clr  = 1'b0;
        crc_step = 1'b0;
        crc_byte = frame_byte;
        unique case (state)
            S_IDLE:  crc_clr = start;
            S_FILL:  spi_req = 1'b1;
            S_FRAME: begin
                spi_req  = 1'b1;
                spi_tx   = frame_byte;
                crc_step = spi_done && (pos < LAST_FRAME);
            end
            S_POLL:  spi_req = 1'b1;
            S_FIN:   finish  = 1'b1;
            default: ;
        endcase
    end

    assign resp    = resp_q;
    assign no_resp = nores_q;

    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_done) |=> (spi_req && $stable(spi_tx)));
    a_r5_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL && pos == '0 && spi_done) |=> (state == S_POLL));
    a_r7_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL) |-> (pos <= LAST_SLOT));
    a_r9_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);
    a_r11_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_q) |-> finish);
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL && start && !spi_done) |=> (state == S_POLL));
    a_r2_header: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FRAME && pos == '0) |-> (spi_tx[7:6] == 2'b01));
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
    parameter int POLL_SLOTS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    output logic        spi_req,
    output logic [7:0]  spi_tx,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx,
    output logic [7:0]  resp,
    output logic        no_resp,
    output logic        finish
);
    logic       crc_clr;
    logic       crc_step;
    logic [7:0] crc_byte;
    logic [6:0] crc_val;

    sd_cmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .step  (crc_step),
        .din   (crc_byte),
        .crc   (crc_val)
    );

    sd_cmd_seq #(.POLL_SLOTS(POLL_SLOTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .crc_val   (crc_val),
        .crc_clr   (crc_clr),
        .crc_step  (crc_step),
        .crc_byte  (crc_byte),
        .spi_req   (spi_req),
        .spi_tx    (spi_tx),
        .spi_done  (spi_done),
        .spi_rx    (spi_rx),
        .resp      (resp),
        .no_resp   (no_resp),
        .finish    (finish)
    );

    // R8: flag agrees with reported byte whenever a command completes
    a_r8_noresp: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (no_resp == (resp == 8'hFF)));
endmodule

// File: tb/sd_cmd_framer_test.sv
module sd_cmd_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        spi_req;
    logic [7:0]  spi_tx;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = 8'h00;
    logic [7:0]  resp;
    logic        no_resp;
    logic        finish;

    int total = 0;
    int bad = 0;
    int nxfer = 0;
    logic [7:0] tx_log [0:31];
    logic [7:0] poll_rx [0:7];

    always #5 clk = ~clk;

    sd_cmd_framer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx), .resp(resp),
        .no_resp(no_resp), .finish(finish)
    );

    // byte-level SPI master model
    always begin
        @(negedge clk);
        if (spi_req) begin
            int d;
            if (nxfer < 32) tx_log[nxfer] = spi_tx;
            d = $urandom_range(0, 3);
            repeat (d) @(negedge clk);
            spi_rx = (nxfer < 7) ? 8'hFF : ((nxfer - 7 < 8) ? poll_rx[nxfer - 7] : 8'hFF);
            spi_done = 1'b1;
            @(negedge clk);
            spi_done = 1'b0;
            nxfer++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(input logic [39:0] bits);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = c[6] ^ bits[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic ref_reply(output logic [7:0] st, output int slots);
        st = poll_rx[7];
        slots = 8;
        for (int k = 7; k >= 1; k--)
            if (!poll_rx[k][7]) begin st = poll_rx[k]; slots = k + 1; end
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit extra_go);
        logic [7:0] exp_st;
        int         exp_slots;
        logic [7:0] prev;
        logic [7:0] exp_frame [0:6];
        int cyc = 0;
        int fins = 0;
        ref_reply(exp_st, exp_slots);
        exp_frame[0] = 8'hFF;
        exp_frame[1] = {2'b01, idx};
        exp_frame[2] = arg[31:24];
        exp_frame[3] = arg[23:16];
        exp_frame[4] = arg[15:8];
        exp_frame[5] = arg[7:0];
        exp_frame[6] = {ref_crc7({2'b01, idx, arg}), 1'b1};
        prev = resp;
        nxfer = 0;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!finish && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (extra_go && cyc == 20) begin
                cmd_index = ~idx; cmd_arg = ~arg; start = 1'b1;
            end else start = 1'b0;
            if (!finish && resp !== prev) check(0, "R11 resp changed early", resp, prev);
        end
        check(finish === 1'b1, "R9 finish seen (watchdog)", finish, 1);
        check(resp === exp_st, "R6/R7 reply", resp, exp_st);
        check(no_resp === (exp_st == 8'hFF), "R8 no_resp", no_resp, exp_st == 8'hFF);
        @(negedge clk);
        start = 1'b0;
        check(finish === 1'b0, "R9 one-cycle pulse", finish, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (finish) fins++;
        end
        check(fins == 0, "R10 single finish", fins, 0);
        check(nxfer == 7 + exp_slots, "R6/R7 transfer count", nxfer, 7 + exp_slots);
        check(tx_log[0] === exp_frame[0], "R1 filler", tx_log[0], exp_frame[0]);
        check(tx_log[1] === exp_frame[1], "R2 header", tx_log[1], exp_frame[1]);
        for (int i = 2; i < 6; i++)
            check(tx_log[i] === exp_frame[i], "R3 argument byte", tx_log[i], exp_frame[i]);
        check(tx_log[6] === exp_frame[6], "R4 trailer", tx_log[6], exp_frame[6]);
        for (int i = 7; i < nxfer && i < 32; i++)
            check(tx_log[i] === 8'hFF, "R6 poll filler", tx_log[i], 8'hFF);
        check(resp === exp_st, "R11 resp held", resp, exp_st);
    endtask

    task automatic fill_poll(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] rest);
        poll_rx[0] = b0; poll_rx[1] = b1;
        for (int k = 2; k < 8; k++) poll_rx[k] = rest;
    endtask

    initial begin
        void'($urandom(32'd1234));
        fill_poll(8'hFF, 8'hFF, 8'hFF);
        repeat (3) @(negedge clk);
        check(spi_req === 1'b0, "R12 spi_req", spi_req, 0);
        check(finish === 1'b0, "R12 finish", finish, 0);
        check(resp === 8'h00, "R12 resp", resp, 0);
        check(no_resp === 1'b0, "R12 no_resp", no_resp, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: command 0, argument 0 yields trailer 0x95; reply in slot 2
        fill_poll(8'hFF, 8'h01, 8'hFF);
        run_cmd(6'd0, 32'h0, 1'b0);
        check(tx_log[6] === 8'h95, "R4 known trailer 0x95", tx_log[6], 8'h95);
        check(resp === 8'h01, "R6 idle reply", resp, 8'h01);

        // R4: command 8, argument 0x1AA yields 0x87
        fill_poll(8'hFF, 8'hFF, 8'h05);
        run_cmd(6'd8, 32'h0000_01AA, 1'b0);
        check(tx_log[6] === 8'h87, "R4 known trailer 0x87", tx_log[6], 8'h87);

        // R5: bit-7-clear byte in first slot is skipped
        fill_poll(8'h00, 8'hFF, 8'h04);
        run_cmd(6'd17, 32'h1234_5678, 1'b0);
        check(resp === 8'h04, "R5 first slot skipped", resp, 8'h04);

        // R7/R8: no card
        fill_poll(8'hFF, 8'hFF, 8'hFF);
        run_cmd(6'd55, 32'hFFFF_FFFF, 1'b0);
        check(no_resp === 1'b1, "R8 no card", no_resp, 1);

        // R7: all bit 7 set but last not 0xFF
        fill_poll(8'h80, 8'hC1, 8'h9A);
        poll_rx[7] = 8'hC3;
        run_cmd(6'd41, 32'h4000_0000, 1'b0);
        check(resp === 8'hC3, "R7 last byte", resp, 8'hC3);
        check(no_resp === 1'b0, "R8 not no-card", no_resp, 0);

        // R10: start while busy
        fill_poll(8'hFF, 8'hFF, 8'h00);
        run_cmd(6'd24, 32'hA5A5_0F0F, 1'b1);

        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] b = 8'($urandom);
                poll_rx[k] = ($urandom_range(0, 3) != 0) ? (b | 8'h80) : (b & 8'h7F);
            end
            run_cmd(6'($urandom), $urandom, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule